// File: doc/BRIEF.md
# Programmable Asynchronous Serial Line

This block is one full-duplex asynchronous serial line of a multi-line terminal multiplexer. A single configuration write sets the character size, the stop length, the parity mode and the line speed. The transmitter and the receiver both take their timing from one rate generator, so they always run at the same speed. On the transmit side, a parallel character becomes a frame made of a low start bit, the data bits sent least significant bit first, an optional parity bit and a high stop period. The transmitter can also hold the line at space to send a break.

The receiver samples the incoming line at sixteen times the bit rate. It rejects start bits that are too short, and it accepts a stop bit that lasts only half a bit time. Each character goes into a holding register together with its framing, parity, overrun and break flags. An external scanner reads the character from there and removes it with a take strobe. A receive enable turns the receiver on and off.

Top module: `serial_line`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then a high stop period. A character that is looped back comes out of the receiver as the data masked to the chosen length, with the upper bits zero.
- R2: With `cfg_stop2` clear, the stop period is 1 bit time. With `cfg_stop2` set, it is 2 bit times for 6 to 8 data bits and 1.5 bit times for 5 data bits.
- R3: With `cfg_par_en` set, a parity bit follows the data. If `cfg_par_odd` is 0, the data bits and the parity bit together hold an even number of ones; if it is 1, they hold an odd number. A received parity bit that does not match sets `rx_perr` for that character.
- R4: `cfg_speed` picks one rate from the list 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600, 19800 (codes 0 to 15 in that order). One bit time is 16 x D clocks, where D = floor((CLK_HZ*10 + 8*R10) / (16*R10)) and R10 is ten times the rate. The transmitter and the receiver share this rate.
- R5: The receiver accepts a stop bit that lasts half a bit time. A next start bit that follows at once is received correctly.
- R6: A low pulse on `rxd` shorter than half a bit time is a false start. It delivers no character, and a later valid frame is still received.
- R7: A stop bit sampled low sets `rx_ferr`. `rx_brk` is set when that happens and all data bits are zero. After a framing error the receiver waits for the line to return to mark before it looks for a new start bit.
- R8: A character that completes while `rx_valid` is set and no take is given overwrites the holding register and sets `rx_ovr`. `rx_take` clears `rx_valid` and all flags on the next clock.
- R9: While `rx_en` is low, no character is delivered and any frame in progress is dropped.
- R10: While `brk_tx` is high, `txd` is low from the next clock on, even during a frame. An idle transmitter drives `txd` high.
- R11: After reset, `txd` is 1, `tx_ready` is 1, and `rx_valid` and all receive flags are 0.
- R12: `tx_load` is accepted only while `tx_ready` is high. A load given while a frame is being sent has no effect and adds no extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Writes the configuration fields |
| cfg_len | input | 2 | Data bit count code (0 = 5 bits to 3 = 8 bits) |
| cfg_stop2 | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when set, even when clear |
| cfg_speed | input | 4 | Line rate code |
| rx_en | input | 1 | Receiver enable |
| tx_load | input | 1 | Strobe that starts a character |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmitter can accept a character |
| brk_tx | input | 1 | Hold the line at space |
| txd | output | 1 | Serial output, high at mark |
| rxd | input | 1 | Serial input, high at mark |
| rx_take | input | 1 | Scanner removes the held character |
| rx_valid | output | 1 | Holding register is full |
| rx_char | output | 8 | Received character, right aligned |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ovr | output | 1 | The held character overwrote one that was not taken |
| rx_brk | output | 1 | The held character was a break |

## Verification
The properties assume that configuration is written only while both directions are idle. They also assume that `brk_tx` and `rx_en` change on clock edges and that `rx_take` is given only to drain a character. The bench writes configuration only between frames and drives every input at the falling clock edge. Serial stimulus is timed in whole ticks of the configured rate, with the `rxd` line held at mark between frames, except in the cases that break or shorten a frame on purpose.

// File: rtl/serial_line_pkg.sv
package serial_line_pkg;

  localparam int CHAR_W  = 8;
  localparam int N_RATES = 16;
  localparam int OVS     = 16;   // samples per bit

  typedef struct packed {
    logic [1:0] len;
    logic       stop2;
    logic       par_en;
    logic       par_odd;
    logic [3:0] speed;
  } line_cfg_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_MARK} rx_state_e;

  // line rate times ten, indexed by speed code
  function automatic longint rate_x10(input int code);
    case (code)
      0:  return 500;
      1:  return 750;
      2:  return 1100;
      3:  return 1345;
      4:  return 1500;
      5:  return 3000;
      6:  return 6000;
      7:  return 12000;
      8:  return 18000;
      9:  return 20000;
      10: return 24000;
      11: return 36000;
      12: return 48000;
      13: return 72000;
      14: return 96000;
      default: return 198000;
    endcase
  endfunction

  function automatic int calc_div(input longint clk_hz, input int code);
    longint r;
    longint d;
    r = rate_x10(code);
    d = (clk_hz * 10 + 8 * r) / (16 * r);
    if (d < 1) d = 1;
    return int'(d);
  endfunction

  function automatic logic [3:0] nbits(input logic [1:0] len);
    return 4'(len) + 4'd5;
  endfunction

  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len);
    return {CHAR_W{1'b1}} >> (2'd3 - len);
  endfunction

  // stop period in sample ticks: 1, 1.5 or 2 bits
  function automatic logic [5:0] stop_ticks(input logic [1:0] len, input logic stop2);
    if (!stop2)          return 6'd16;
    else if (len == 2'd0) return 6'd24;
    else                 return 6'd32;
  endfunction

endpackage

// File: rtl/sl_baud_gen.sv
module sl_baud_gen
  import serial_line_pkg::*;
#(
  parameter int CLK_HZ = 3_168_000,
  parameter int DIV_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [3:0] speed,
  output logic       tick
);

  logic [DIV_W-1:0] div_tab [N_RATES];
  logic [DIV_W-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    assign div_tab[g] = DIV_W'(calc_div(CLK_HZ, g));
  end

  always_comb begin
    tick = (cnt_q == '0) && !restart;
    if (restart || cnt_q == '0) cnt_d = div_tab[speed] - 1'b1;
    else                        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sl_tx.sv
module sl_tx
  import serial_line_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              stop2,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              load,
  input  logic [CHAR_W-1:0] data,
  input  logic              brk,
  output logic              ready,
  output logic              txd
);

  tx_state_e         st_q, st_d;
  logic [5:0]        cnt_q, cnt_d;
  logic [3:0]        bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              pend_q, pend_d;
  logic              txd_q, txd_d;
  logic [CHAR_W-1:0] masked;
  logic [5:0]        limit;
  logic              bit_end;
  logic              line;

  always_comb begin
    masked  = data & char_mask(len);
    limit   = (st_q == TX_STOP) ? stop_ticks(len, stop2) : 6'(OVS);
    bit_end = tick && (cnt_q == limit - 6'd1);
    ready   = (st_q == TX_IDLE) && !pend_q;

    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    pend_d = pend_q;
    line   = 1'b1;

    if (st_q != TX_IDLE && tick) cnt_d = bit_end ? 6'd0 : cnt_q + 6'd1;

    case (st_q)
      TX_IDLE: begin
        if (load && !pend_q) begin
          sh_d   = masked;
          par_d  = (^masked) ^ par_odd;
          pend_d = 1'b1;
        end else if (pend_q && tick) begin
          st_d   = TX_START;
          cnt_d  = 6'd0;
          pend_d = 1'b0;
        end
      end
      TX_START: begin
        line = 1'b0;
        if (bit_end) begin
          st_d  = TX_DATA;
          bit_d = 4'd0;
        end
      end
      TX_DATA: begin
        line = sh_q[0];
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (bit_q == nbits(len) - 4'd1) st_d = par_en ? TX_PAR : TX_STOP;
          else                            bit_d = bit_q + 4'd1;
        end
      end
      TX_PAR: begin
        line = par_q;
        if (bit_end) st_d = TX_STOP;
      end
      TX_STOP: begin
        line = 1'b1;
        if (bit_end) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase

    txd_d = brk ? 1'b0 : line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      pend_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      pend_q <= pend_d;
      txd_q  <= txd_d;
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/sl_rx.sv
module sl_rx
  import serial_line_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              en,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] char_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic              brk_o
);

  localparam logic [3:0] MID_T  = 4'(OVS / 2 - 1);
  localparam logic [3:0] BIT_T  = 4'(OVS - 1);
  localparam logic [3:0] STOP_T = 4'(OVS - 3);  // early stop sample, tolerates a half-length stop

  rx_state_e         st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [3:0]        bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              perr_q, perr_d;

  always_comb begin
    char_o = sh_q >> (4'(CHAR_W) - nbits(len));
    ferr_o = !rxd;
    perr_o = perr_q;
    brk_o  = ferr_o && (char_o == '0);
    done   = 1'b0;

    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    perr_d = perr_q;

    case (st_q)
      RX_IDLE: begin
        if (tick && !rxd) begin
          st_d  = RX_START;
          cnt_d = 4'd0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID_T) begin
            cnt_d  = 4'd0;
            bit_d  = 4'd0;
            perr_d = 1'b0;
            st_d   = rxd ? RX_IDLE : RX_DATA;
          end else cnt_d = cnt_q + 4'd1;
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == BIT_T) begin
            cnt_d = 4'd0;
            sh_d  = {rxd, sh_q[CHAR_W-1:1]};
            if (bit_q == nbits(len) - 4'd1) st_d = par_en ? RX_PAR : RX_STOP;
            else                            bit_d = bit_q + 4'd1;
          end else cnt_d = cnt_q + 4'd1;
        end
      end
      RX_PAR: begin
        if (tick) begin
          if (cnt_q == BIT_T) begin
            cnt_d  = 4'd0;
            perr_d = rxd ^ (^char_o) ^ par_odd;
            st_d   = RX_STOP;
          end else cnt_d = cnt_q + 4'd1;
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == STOP_T) begin
            done = 1'b1;
            st_d = rxd ? RX_IDLE : RX_MARK;
          end else cnt_d = cnt_q + 4'd1;
        end
      end
      RX_MARK: begin
        if (tick && rxd) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase

    if (!en) begin
      st_d = RX_IDLE;
      done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      perr_q <= perr_d;
    end
  end

endmodule

// File: rtl/serial_line.sv
module serial_line
  import serial_line_pkg::*;
#(
  parameter int CLK_HZ = 3_168_000,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [3:0]        cfg_speed,
  input  logic              rx_en,
  input  logic              tx_load,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              brk_tx,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_take,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_char,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              rx_ovr,
  output logic              rx_brk
);

  line_cfg_t         cfg_q, cfg_d;
  logic [1:0]        sync_q;
  logic              tick;
  logic              rx_done;
  logic [CHAR_W-1:0] rx_c;
  logic              rx_fe, rx_pe, rx_bk;

  logic              hv_q, hv_d;
  logic [CHAR_W-1:0] hc_q, hc_d;
  logic              hf_q, hf_d, hp_q, hp_d, ho_q, ho_d, hb_q, hb_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = '{len: cfg_len, stop2: cfg_stop2, par_en: cfg_par_en,
                          par_odd: cfg_par_odd, speed: cfg_speed};
  end

  sl_baud_gen #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .speed(cfg_q.speed), .tick(tick)
  );

  sl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .len(cfg_q.len), .stop2(cfg_q.stop2), .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .load(tx_load), .data(tx_data), .brk(brk_tx), .ready(tx_ready), .txd(txd)
  );

  sl_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .len(cfg_q.len), .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .en(rx_en && !cfg_we), .rxd(sync_q[1]),
    .done(rx_done), .char_o(rx_c), .ferr_o(rx_fe), .perr_o(rx_pe), .brk_o(rx_bk)
  );

  // holding stage of the double buffer
  always_comb begin
    hv_d = hv_q; hc_d = hc_q; hf_d = hf_q; hp_d = hp_q; ho_d = ho_q; hb_d = hb_q;
    if (rx_done) begin
      hv_d = 1'b1;
      hc_d = rx_c;
      hf_d = rx_fe;
      hp_d = rx_pe;
      hb_d = rx_bk;
      ho_d = hv_q && !rx_take;
    end else if (rx_take) begin
      hv_d = 1'b0; hf_d = 1'b0; hp_d = 1'b0; ho_d = 1'b0; hb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{len: 2'd3, stop2: 1'b0, par_en: 1'b0, par_odd: 1'b0, speed: 4'hF};
      sync_q <= 2'b11;
      hv_q   <= 1'b0;
      hc_q   <= '0;
      hf_q   <= 1'b0;
      hp_q   <= 1'b0;
      ho_q   <= 1'b0;
      hb_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      sync_q <= {sync_q[0], rxd};
      hv_q   <= hv_d;
      hc_q   <= hc_d;
      hf_q   <= hf_d;
      hp_q   <= hp_d;
      ho_q   <= ho_d;
      hb_q   <= hb_d;
    end
  end

  assign rx_valid = hv_q;
  assign rx_char  = hc_q;
  assign rx_ferr  = hf_q;
  assign rx_perr  = hp_q;
  assign rx_ovr   = ho_q;
  assign rx_brk   = hb_q;

endmodule

// File: rtl/serial_line_chk.sv
module serial_line_chk
  import serial_line_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              brk_tx,
  input logic              txd,
  input logic              tx_load,
  input logic              tx_ready,
  input logic              rx_en,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_ferr,
  input logic              rx_ovr,
  input logic              rx_brk
);

  p_break_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk_tx) |-> !txd);

  p_idle_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && $past(tx_ready) && !$past(brk_tx)) |-> txd);

  p_load_taken_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready) |=> !tx_ready);

  p_brk_is_ferr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk |-> (rx_ferr && rx_char == '0));

  p_ovr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_valid);

  p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_valid) |=> !rx_valid);

endmodule

bind serial_line serial_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_tx(brk_tx), .txd(txd), .tx_load(tx_load),
  .tx_ready(tx_ready), .rx_en(rx_en), .rx_valid(rx_valid), .rx_char(rx_char),
  .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rx_brk(rx_brk)
);

// File: tb/tb_serial_line.sv
`timescale 1ns/1ps
module tb_serial_line;

  localparam longint TB_CLK_HZ = 3_168_000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_len;
  logic       cfg_stop2, cfg_par_en, cfg_par_odd;
  logic [3:0] cfg_speed;
  logic       rx_en, tx_load, brk_tx, rx_take;
  logic [7:0] tx_data;
  logic       tx_ready, txd, rxd;
  logic       rx_valid, rx_ferr, rx_perr, rx_ovr, rx_brk;
  logic [7:0] rx_char;
  logic       loop_en, drv;

  int n_tests = 0;
  int n_fail  = 0;
  int div_cur = 10;

  always #2.5 clk = ~clk;
  assign rxd = loop_en ? txd : drv;

  serial_line dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_stop2(cfg_stop2),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_speed(cfg_speed),
    .rx_en(rx_en), .tx_load(tx_load), .tx_data(tx_data), .tx_ready(tx_ready),
    .brk_tx(brk_tx), .txd(txd), .rxd(rxd), .rx_take(rx_take), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr), .rx_brk(rx_brk)
  );

  // {len[24:23], par_en[22], par_odd[21], stop2[20], speed[19:16], data[15:8], expected char[7:0]}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 4'd15, 8'hA5, 8'hA5},
    {2'd0, 1'b1, 1'b0, 1'b1, 4'd15, 8'hF3, 8'h13},
    {2'd1, 1'b1, 1'b1, 1'b0, 4'd15, 8'hFF, 8'h3F},
    {2'd2, 1'b1, 1'b0, 1'b1, 4'd15, 8'hDA, 8'h5A},
    {2'd3, 1'b1, 1'b1, 1'b1, 4'd14, 8'h00, 8'h00},
    {2'd3, 1'b1, 1'b0, 1'b0, 4'd15, 8'h81, 8'h81}
  };

  function automatic int bench_div(input int code);
    longint r;
    case (code)
      13: r = 72000;
      14: r = 96000;
      default: r = 198000;
    endcase
    return int'((TB_CLK_HZ * 10 + 8 * r) / (16 * r));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input bit pe, input bit po, input bit st,
                         input logic [3:0] sp);
    @(negedge clk);
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = st; cfg_speed = sp;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    div_cur = bench_div(int'(sp));
  endtask

  task automatic send_tx(input logic [7:0] d);
    do @(negedge clk); while (!tx_ready);
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic hold_ticks(input int t);
    repeat (t * div_cur) @(negedge clk);
  endtask

  task automatic capture_tx(input int nsamp, output logic [11:0] bits);
    bits = '0;
    do @(negedge clk); while (txd !== 1'b0);
    hold_ticks(8);
    bits[0] = txd;
    for (int i = 1; i < nsamp; i++) begin
      hold_ticks(16);
      bits[i] = txd;
    end
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 40 * 16 * div_cur; i++) begin
      @(negedge clk);
      if (rx_valid) break;
    end
  endtask

  task automatic take();
    @(negedge clk); rx_take = 1'b1;
    @(negedge clk); rx_take = 1'b0;
  endtask

  task automatic wait_tx_idle();
    do @(negedge clk); while (!tx_ready);
    hold_ticks(4);
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nb, input bit pe, input bit po,
                             input bit badpar, input int stop_half, input bit badstop);
    bit p;
    p = po;
    drv = 1'b0; hold_ticks(16);
    for (int i = 0; i < nb; i++) begin
      drv = d[i]; p = p ^ d[i]; hold_ticks(16);
    end
    if (pe) begin drv = p ^ badpar; hold_ticks(16); end
    if (badstop) begin
      drv = 1'b0; hold_ticks(16);
      drv = 1'b1; hold_ticks(32);
    end else begin
      drv = 1'b1; hold_ticks(8 * stop_half);
    end
  endtask

  task automatic check_rx(input string req, input logic [7:0] c, input bit fe, input bit pe,
                          input bit ov, input bit bk);
    chk(rx_valid === 1'b1, req, "rx_valid", rx_valid, 1);
    chk({rx_char, rx_ferr, rx_perr, rx_ovr, rx_brk} === {c, fe, pe, ov, bk}, req,
        "char/ferr/perr/ovr/brk", {rx_char, rx_ferr, rx_perr, rx_ovr, rx_brk}, {c, fe, pe, ov, bk});
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] got, expf;
    int nb, ns, cyc, lo, hi;
    logic [7:0] c1, c2;
    bit f1, f2;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_len = 2'd3; cfg_stop2 = 1'b0; cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0; cfg_speed = 4'd15; rx_en = 1'b0; tx_load = 1'b0; tx_data = '0;
    brk_tx = 1'b0; rx_take = 1'b0; loop_en = 1'b0; drv = 1'b1;
    repeat (10) @(negedge clk);
    // R11: reset state
    chk({txd, tx_ready, rx_valid, rx_ferr, rx_perr, rx_ovr, rx_brk} === 7'b1100000, "R11",
        "reset outputs", {txd, tx_ready, rx_valid, rx_ferr, rx_perr, rx_ovr, rx_brk}, 7'b1100000);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3 R4: vector table, frame shape on txd and looped-back character
    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][24:23], VEC[v][22], VEC[v][21], VEC[v][20], VEC[v][19:16]);
      loop_en = 1'b1;
      nb = int'(VEC[v][24:23]) + 5;
      ns = nb + 2 + (VEC[v][22] ? 1 : 0);
      expf = '0;
      begin
        bit p;
        p = VEC[v][21];
        for (int i = 0; i < nb; i++) begin expf[1 + i] = VEC[v][8 + i]; p = p ^ VEC[v][8 + i]; end
        if (VEC[v][22]) expf[1 + nb] = p;
        expf[ns - 1] = 1'b1;
      end
      fork
        send_tx(VEC[v][15:8]);
        capture_tx(ns, got);
      join
      chk(got === expf, "R1/R3", "tx frame bits", got, expf);
      wait_rx();
      check_rx("R1/R3/R4 loopback", VEC[v][7:0], 0, 0, 0, 0);
      take();
      wait_tx_idle();
    end
    loop_en = 1'b0;

    // R4: bit time per speed code
    for (int k = 13; k <= 15; k++) begin
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 4'(k));
      fork
        send_tx(8'h01);
        begin
          do @(negedge clk); while (txd !== 1'b0);
          cyc = 0;
          do begin @(negedge clk); cyc++; end while (txd !== 1'b1);
        end
      join
      chk(cyc >= 16 * div_cur - 1 && cyc <= 16 * div_cur + 1, "R4", "bit time clocks",
          cyc, 16 * div_cur);
      wait_tx_idle();
    end

    // R2: stop length 1, 1.5, 2 bits, measured between back-to-back frames
    for (int k = 0; k < 3; k++) begin
      int st_t;
      if (k == 0) begin set_cfg(2'd0, 0, 0, 0, 4'd15); st_t = 16; end
      else if (k == 1) begin set_cfg(2'd0, 0, 0, 1, 4'd15); st_t = 24; end
      else begin set_cfg(2'd3, 0, 0, 1, 4'd15); st_t = 32; end
      fork
        begin send_tx(8'h00); send_tx(8'h00); end
        begin
          do @(negedge clk); while (txd !== 1'b0);
          do @(negedge clk); while (txd !== 1'b1);
          cyc = 0;
          do begin @(negedge clk); cyc++; end while (txd !== 1'b0);
        end
      join
      lo = st_t * div_cur; hi = st_t * div_cur + div_cur + 4;
      chk(cyc >= lo && cyc <= hi, "R2", "stop period clocks", cyc, lo);
      wait_tx_idle();
    end

    // R3: parity mismatch on receive
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 4'd15);
    drive_frame(8'h3C, 8, 1, 0, 1, 2, 0);
    check_rx("R3 bad parity", 8'h3C, 0, 1, 0, 0);
    take();

    // R5: half-length stop followed at once by the next start
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 4'd15);
    fork
      begin
        drive_frame(8'h55, 8, 0, 0, 0, 1, 0);
        drive_frame(8'hAA, 8, 0, 0, 0, 2, 0);
      end
      begin
        wait_rx(); c1 = rx_char; f1 = rx_ferr; take();
        wait_rx(); c2 = rx_char; f2 = rx_ferr | rx_ovr;
      end
    join
    chk({c1, f1} === {8'h55, 1'b0}, "R5", "first char after short stop", {c1, f1}, {8'h55, 1'b0});
    chk({c2, f2} === {8'hAA, 1'b0}, "R5", "second char", {c2, f2}, {8'hAA, 1'b0});
    take();

    // R6: false start
    drv = 1'b0; hold_ticks(4); drv = 1'b1;
    hold_ticks(16 * 14);
    chk(rx_valid === 1'b0, "R6", "no char from glitch", rx_valid, 0);
    drive_frame(8'h42, 8, 0, 0, 0, 2, 0);
    check_rx("R6 frame after glitch", 8'h42, 0, 0, 0, 0);
    take();

    // R7: break, then plain framing error, then recovery
    drv = 1'b0; hold_ticks(16 * 12); drv = 1'b1; hold_ticks(32);
    check_rx("R7 break", 8'h00, 1, 0, 0, 1);
    take();
    drive_frame(8'h81, 8, 0, 0, 0, 0, 1);
    check_rx("R7 framing error", 8'h81, 1, 0, 0, 0);
    take();
    drive_frame(8'h33, 8, 0, 0, 0, 2, 0);
    check_rx("R7 recovery", 8'h33, 0, 0, 0, 0);
    take();

    // R8: overrun and take
    drive_frame(8'h11, 8, 0, 0, 0, 2, 0);
    drive_frame(8'h22, 8, 0, 0, 0, 2, 0);
    check_rx("R8 overrun", 8'h22, 0, 0, 1, 0);
    take();
    chk({rx_valid, rx_ovr} === 2'b00, "R8", "cleared by take", {rx_valid, rx_ovr}, 0);

    // R9: receiver disabled
    rx_en = 1'b0;
    drive_frame(8'h77, 8, 0, 0, 0, 2, 0);
    hold_ticks(16);
    chk(rx_valid === 1'b0, "R9", "no char while disabled", rx_valid, 0);
    rx_en = 1'b1;
    hold_ticks(16);
    drive_frame(8'h78, 8, 0, 0, 0, 2, 0);
    check_rx("R9 re-enabled", 8'h78, 0, 0, 0, 0);
    take();

    // R10: break transmit overrides an active frame
    @(negedge clk); brk_tx = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(txd === 1'b0, "R10", "txd at space", txd, 0);
    send_tx(8'hFF);
    hold_ticks(16 * 5);
    chk(txd === 1'b0, "R10", "txd space during frame", txd, 0);
    brk_tx = 1'b0;
    wait_tx_idle();
    chk(txd === 1'b1, "R10", "idle mark", txd, 1);

    // R12: load while busy is ignored
    loop_en = 1'b1;
    send_tx(8'hC3);
    repeat (40) @(negedge clk);
    chk(tx_ready === 1'b0, "R12", "busy during frame", tx_ready, 0);
    tx_data = 8'h3C; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
    wait_rx();
    check_rx("R12 first frame", 8'hC3, 0, 0, 0, 0);
    take();
    hold_ticks(16 * 15);
    chk({rx_valid, tx_ready} === 2'b01, "R12", "no extra frame", {rx_valid, tx_ready}, 2'b01);

    summary();
    $finish;
  end

endmodule